// File: doc/BRIEF.md
# Split-Write Dual-Read Register File

This block is a bank of 32 general-purpose registers, each 32 bits wide. It has two combinational read ports and one 64-bit write bus. The write bus is split into an upper and a lower 32-bit half. Each half has its own destination address and its own enable, and both halves are written on the same clock edge. A datapath can therefore store a full 64-bit product in two registers in a single cycle, while ordinary 32-bit results use only one half.

A pairing input makes the low-half destination follow the high-half destination plus one, wrapping modulo 32. When this input is high, the caller only has to supply one destination address to place a double-width result in consecutive registers. While the active-high reset is asserted, every write is blocked. Register contents are never cleared by reset.

Top module: `splitWriteRegFile`

## Requirements
- R1: Port A always presents, combinationally, the 32-bit contents of the register selected by `rdAddrA` (0 to 31).
- R2: Port B always presents, combinationally, the contents of the register selected by `rdAddrB`, independently of port A.
- R3: With `wrEnHi` at 1, bits 63:32 of `wrData` are stored on the rising clock edge into the register named by `wrAddrHi`.
- R4: With `wrEnLo` at 1, bits 31:0 of `wrData` are stored on the rising clock edge into the register named by the low destination (`wrAddrLo` when `pairWrite` is 0).
- R5: With both enables at 1 and different destinations, both registers are updated on the same edge.
- R6: A half whose enable is 0 writes nothing. With both enables at 0, no register changes.
- R7: When both halves name the same register on one edge, that register takes the low half (`wrData[31:0]`).
- R8: With `pairWrite` at 1, the low destination is `(wrAddrHi + 1) mod 32` and `wrAddrLo` is ignored, so a high destination of 31 sends the low half to register 0.
- R9: The read ports show the contents from before the edge. A write being set up in the current cycle does not appear on a read port until after its edge.
- R10: While `rst` is 1, no register changes, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high reset; blocks all writes |
| rdAddrA | input | 5 | Register index for read port A |
| rdDataA | output | 32 | Contents of register `rdAddrA` |
| rdAddrB | input | 5 | Register index for read port B |
| rdDataB | output | 32 | Contents of register `rdAddrB` |
| wrData | input | 64 | Write bus; upper half bits 63:32, lower half bits 31:0 |
| wrAddrHi | input | 5 | Destination of the upper half |
| wrAddrLo | input | 5 | Destination of the lower half when not paired |
| wrEnHi | input | 1 | Enable for the upper-half write |
| wrEnLo | input | 1 | Enable for the lower-half write |
| pairWrite | input | 1 | 1: lower destination is `wrAddrHi + 1` mod 32 |

## Verification
On every cycle, the assertions check the write-strobe decode:
- at most one strobe per half;
- no strobes when both enables are low or when reset is high;
- the paired low strobe lands on the wrapped neighbour of the high address;
- the high strobe is dropped on a same-address clash.

Per register, they also check that a strobed half arrives on the next edge and that an unstrobed register holds its value. Only the bench's scenarios can show what is seen at the ports: that reads through either port return what the requirements predict for every register, that the old value is read before the edge, and that values written under reset never become visible.

// File: rtl/rfSplitPkg.sv
`timescale 1ns/1ps
package rfSplitPkg;
  localparam int RF_DEPTH = 32;
  localparam int RF_WIDTH = 32;
  localparam int RF_AW    = $clog2(RF_DEPTH);
  localparam int BUS_W    = 2 * RF_WIDTH;

  // One-hot-or-zero write strobes per register for each half of the bus
  typedef struct packed {
    logic [RF_DEPTH-1:0] hiSel;
    logic [RF_DEPTH-1:0] loSel;
  } rfStrobe_t;
endpackage

// File: rtl/rfWriteCtrl.sv
`timescale 1ns/1ps
module rfWriteCtrl
  import rfSplitPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [RF_AW-1:0] wrAddrHi,
  input  logic [RF_AW-1:0] wrAddrLo,
  input  logic             wrEnHi,
  input  logic             wrEnLo,
  input  logic             pairWrite,
  output rfStrobe_t        strobes
);
  logic [RF_AW-1:0] loDest;
  logic [RF_AW-1:0] pairDest;

  // Neighbour address wraps naturally in RF_AW bits
  assign pairDest = wrAddrHi + RF_AW'(1);
  assign loDest   = pairWrite ? pairDest : wrAddrLo;

  for (genvar i = 0; i < RF_DEPTH; i++) begin : gDecode
    localparam logic [RF_AW-1:0] IDX = RF_AW'(i);
    logic loHit;
    logic hiHit;
    assign loHit = !rst && wrEnLo && (loDest == IDX);
    assign hiHit = !rst && wrEnHi && (wrAddrHi == IDX);
    assign strobes.loSel[i] = loHit;
    // Low half wins a same-register clash
    assign strobes.hiSel[i] = hiHit && !loHit;
  end

  AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.hiSel)); // R3
  AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.loSel)); // R4
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!wrEnHi && !wrEnLo) |-> (strobes == '0)); // R6
  AST_CLASH_LO_WINS: assert property (@(posedge clk) disable iff (rst)
    (wrEnHi && wrEnLo && !pairWrite && wrAddrHi == wrAddrLo) |-> (strobes.hiSel == '0)); // R7
  AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pairWrite && wrEnLo) |-> strobes.loSel[RF_AW'(wrAddrHi + RF_AW'(1))]); // R8
  AST_BOTH_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    (wrEnHi && wrEnLo && !pairWrite && wrAddrHi != wrAddrLo)
      |-> ($countones(strobes.hiSel) == 1 && $countones(strobes.loSel) == 1)); // R5
  always_comb begin
    if (rst) AST_RST_BLOCKS: assert (strobes == '0); // R10
  end
endmodule

// File: rtl/rfDatapath.sv
`timescale 1ns/1ps
module rfDatapath
  import rfSplitPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  rfStrobe_t           strobes,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [RF_AW-1:0]    rdAddrA,
  input  logic [RF_AW-1:0]    rdAddrB,
  output logic [RF_WIDTH-1:0] rdDataA,
  output logic [RF_WIDTH-1:0] rdDataB
);
  logic [RF_DEPTH-1:0][RF_WIDTH-1:0] regBank;
  logic [RF_WIDTH-1:0] hiData;
  logic [RF_WIDTH-1:0] loData;

  assign hiData = wrData[BUS_W-1:RF_WIDTH];
  assign loData = wrData[RF_WIDTH-1:0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < RF_DEPTH; i++) begin
      if (strobes.loSel[i])      regBank[i] <= loData;
      else if (strobes.hiSel[i]) regBank[i] <= hiData;
    end
  end

  // Combinational reads, no bypass of the pending write
  assign rdDataA = regBank[rdAddrA];
  assign rdDataB = regBank[rdAddrB];

  for (genvar i = 0; i < RF_DEPTH; i++) begin : gCellChk
    AST_HI_LANDS: assert property (@(posedge clk) disable iff (rst)
      strobes.hiSel[i] |=> (regBank[i] == $past(hiData))); // R3
    AST_LO_LANDS: assert property (@(posedge clk) disable iff (rst)
      strobes.loSel[i] |=> (regBank[i] == $past(loData))); // R4
    AST_CELL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !(strobes.hiSel[i] || strobes.loSel[i]) |=> $stable(regBank[i])); // R6
  end
endmodule

// File: rtl/splitWriteRegFile.sv
`timescale 1ns/1ps
module splitWriteRegFile
  import rfSplitPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [RF_AW-1:0]    rdAddrA,
  output logic [RF_WIDTH-1:0] rdDataA,
  input  logic [RF_AW-1:0]    rdAddrB,
  output logic [RF_WIDTH-1:0] rdDataB,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [RF_AW-1:0]    wrAddrHi,
  input  logic [RF_AW-1:0]    wrAddrLo,
  input  logic                wrEnHi,
  input  logic                wrEnLo,
  input  logic                pairWrite
);
  rfStrobe_t strobes;

  rfWriteCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .wrAddrHi  (wrAddrHi),
    .wrAddrLo  (wrAddrLo),
    .wrEnHi    (wrEnHi),
    .wrEnLo    (wrEnLo),
    .pairWrite (pairWrite),
    .strobes   (strobes)
  );

  rfDatapath uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );
endmodule

// File: tb/tb_splitWriteRegFile.sv
`timescale 1ns/1ps
module tb_splitWriteRegFile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0;
  logic [4:0]  rdAddrB = '0;
  logic [31:0] rdDataA;
  logic [31:0] rdDataB;
  logic [63:0] wrData = '0;
  logic [4:0]  wrAddrHi = '0;
  logic [4:0]  wrAddrLo = '0;
  logic        wrEnHi = 1'b0;
  logic        wrEnLo = 1'b0;
  logic        pairWrite = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  splitWriteRegFile dut (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrData(wrData), .wrAddrHi(wrAddrHi), .wrAddrLo(wrAddrLo),
    .wrEnHi(wrEnHi), .wrEnLo(wrEnLo), .pairWrite(pairWrite)
  );

  typedef struct packed {
    logic        enHi;
    logic        enLo;
    logic        pair;
    logic [4:0]  aHi;
    logic [4:0]  aLo;
    logic [63:0] data;
    logic [7:0]  tag;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 5'd3,  5'd0,  64'hAAAA0003_11111111, 8'd3},  // R3 high half only
    '{1'b0, 1'b1, 1'b0, 5'd0,  5'd7,  64'h22222222_BBBB0007, 8'd4},  // R4 low half only
    '{1'b1, 1'b1, 1'b0, 5'd10, 5'd11, 64'hCAFE000A_F00D000B, 8'd5},  // R5 both halves
    '{1'b0, 1'b0, 1'b0, 5'd12, 5'd13, 64'hDEADDEAD_DEADDEAD, 8'd6},  // R6 nothing enabled
    '{1'b1, 1'b1, 1'b0, 5'd20, 5'd20, 64'h12345678_9ABCDEF0, 8'd7},  // R7 clash, low wins
    '{1'b1, 1'b1, 1'b1, 5'd14, 5'd2,  64'h0E0E0E0E_0F0F0F0F, 8'd8},  // R8 paired 14/15
    '{1'b1, 1'b1, 1'b1, 5'd31, 5'd5,  64'h31313131_00C0FFEE, 8'd8},  // R8 wrap 31 -> 0
    '{1'b1, 1'b0, 1'b1, 5'd25, 5'd6,  64'h25252525_66666666, 8'd6},  // R6 paired, low disabled
    '{1'b0, 1'b1, 1'b1, 5'd8,  5'd4,  64'h88888888_09090909, 8'd6}   // R6 paired, high disabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Read every register through both ports (R1, R2)
  task automatic checkAll(input string req);
    for (int i = 0; i < 32; i += 2) begin
      rdAddrA = 5'(i);
      rdAddrB = 5'(i + 1);
      #1;
      check($sformatf("%s/R1 reg%0d", req, i), rdDataA, model[i]);
      check($sformatf("%s/R2 reg%0d", req, i + 1), rdDataB, model[i + 1]);
    end
  endtask

  task automatic doWrite(input logic eh, input logic el, input logic pr,
                         input logic [4:0] ah, input logic [4:0] al, input logic [63:0] d);
    @(negedge clk);
    wrEnHi = eh; wrEnLo = el; pairWrite = pr;
    wrAddrHi = ah; wrAddrLo = al; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEnHi = 1'b0; wrEnLo = 1'b0; pairWrite = 1'b0;
  endtask

  task automatic modelWrite(input logic eh, input logic el, input logic pr,
                            input logic [4:0] ah, input logic [4:0] al, input logic [63:0] d);
    logic [4:0] lo;
    lo = pr ? 5'(ah + 5'd1) : al;
    if (eh) model[ah] = d[63:32];
    if (el) model[lo] = d[31:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Fill every register with a known value through the low half (R4)
    for (int i = 0; i < 32; i++) begin
      doWrite(1'b0, 1'b1, 1'b0, 5'd0, 5'(i), {32'h0, 32'h5A000000 + 32'(i)});
      model[i] = 32'h5A000000 + 32'(i);
    end
    checkAll("R4 init");

    // Writes under reset have no effect (R10)
    @(negedge clk);
    rst = 1'b1;
    doWrite(1'b1, 1'b1, 1'b0, 5'd4, 5'd6, 64'hBAD0BAD0_BAD1BAD1);
    doWrite(1'b1, 1'b1, 1'b1, 5'd9, 5'd0, 64'hBAD2BAD2_BAD3BAD3);
    rst = 1'b0;
    checkAll("R10 reset");

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      doWrite(VECS[v].enHi, VECS[v].enLo, VECS[v].pair, VECS[v].aHi, VECS[v].aLo, VECS[v].data);
      modelWrite(VECS[v].enHi, VECS[v].enLo, VECS[v].pair, VECS[v].aHi, VECS[v].aLo, VECS[v].data);
      checkAll($sformatf("R%0d vec%0d", VECS[v].tag, v));
    end

    // No bypass: pending write is invisible before its edge (R9)
    @(negedge clk);
    wrEnLo = 1'b1; wrAddrLo = 5'd17; wrData = 64'h0_77770017;
    rdAddrA = 5'd17; rdAddrB = 5'd17;
    #1;
    check("R9 before edge portA", rdDataA, model[17]);
    check("R9 before edge portB", rdDataB, model[17]);
    @(posedge clk);
    #1;
    model[17] = 32'h77770017;
    check("R9 after edge portA", rdDataA, model[17]);
    @(negedge clk);
    wrEnLo = 1'b0;
    checkAll("R9 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule